// File: doc/BRIEF.md
# Bidirectional Latched Bus Transceiver

This block joins two data ports, A and B, through two independent banks of storage, one for each direction of flow. Each direction has three active-low controls: an enable, a latch enable and an output enable. Together they decide whether that direction's bank follows its source port, keeps a value it captured earlier, and drives the opposite port. Each port is a separate input bus, output bus and output-enable flag, so the surrounding logic or pad ring can build the three-state driver.

All logic runs on a single clock. Data and control lines are registered on the way in. A transparent bank reloads from the registered source every cycle. When either of its enable or latch enable rises, the bank keeps the last value it took in. A new input value therefore reaches the opposite port's output two clock edges after it is applied. If both directions ask to drive at once, neither drive flag is raised and a contention flag is raised instead.

Top module: `bus_latch_xcvr`

## Requirements
- R1: While reset is asserted, both output buses read all zeros, both output-enable flags are 0 and the contention flag is 0. Asserting reset clears both banks at once.
- R2: With its enable and latch enable both low, a direction is transparent: two clock edges after its source bus changes, the opposite output bus shows the new value.
- R3: When the latch enable rises while the enable stays low, the bank keeps the source value from before the rise, even if the source bus changes in the same cycle.
- R4: When the enable rises, the bank likewise keeps the source value from before the rise, whatever the latch enable does.
- R5: With the enable low and the latch enable high, source bus changes have no effect on the output bus.
- R6: A direction's output-enable flag is 1 exactly when its enable and output enable are both low and the other direction is not also asking to drive. Its output bus then shows the bank contents.
- R7: If either the enable or the output enable of a direction is high, that direction's output-enable flag is 0. The output bus still shows the bank contents, so a value captured while disabled can be displayed later.
- R8: When both directions ask to drive, both output-enable flags are 0 and the contention flag is 1. The flag clears once only one direction asks.
- R9: The controls and source data of one direction never alter the other direction's bank or output-enable flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| a_in | input | WIDTH | Port A input data (source of the A-to-B bank) |
| a_out | output | WIDTH | Port A output data (contents of the B-to-A bank) |
| a_oe | output | 1 | Port A drive flag |
| b_in | input | WIDTH | Port B input data (source of the B-to-A bank) |
| b_out | output | WIDTH | Port B output data (contents of the A-to-B bank) |
| b_oe | output | 1 | Port B drive flag |
| en_ab_n | input | 1 | A-to-B enable, active low |
| le_ab_n | input | 1 | A-to-B latch enable, active low |
| oe_ab_n | input | 1 | A-to-B output enable, active low |
| en_ba_n | input | 1 | B-to-A enable, active low |
| le_ba_n | input | 1 | B-to-A latch enable, active low |
| oe_ba_n | input | 1 | B-to-A output enable, active low |
| contention | output | 1 | Both directions asked to drive; both drivers held off |

## Verification
The bench builds the block at its defaults, WIDTH of 8 and two reset-release stages. For each direction it walks all eight combinations of enable, latch enable and output enable over eight data patterns. Before each combination the bank is preloaded with the bitwise complement of the new data, so every bit shows whether it was captured, held or passed through. With the bus this narrow, every control combination can be paired with distinct data, while the idle opposite bank is checked for disturbance. Separate runs cover both directions driving at once and a reset asserted while the banks hold data.

// File: rtl/bus_latch_xcvr_pkg.sv
package bus_latch_xcvr_pkg;

  localparam int unsigned NUM_DIRS = 2;
  localparam int unsigned DIR_AB   = 0;
  localparam int unsigned DIR_BA   = 1;

  // Active-low controls of one direction
  typedef struct packed {
    logic en_n;
    logic le_n;
    logic oe_n;
  } dir_ctrl_t;

  localparam dir_ctrl_t CTRL_IDLE = '{en_n: 1'b1, le_n: 1'b1, oe_n: 1'b1};

endpackage

// File: rtl/xcvr_rst_sync.sv
module xcvr_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/xcvr_dir_lane.sv
module xcvr_dir_lane
  import bus_latch_xcvr_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] src_in,
  input  dir_ctrl_t        ctrl_in,
  output logic [WIDTH-1:0] bank_q,
  output logic             drive_req
);

  logic [WIDTH-1:0] src_q;
  dir_ctrl_t        ctrl_q;
  logic [WIDTH-1:0] bank_d;
  logic             bank_ce;

  // Input sampling stage
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q  <= '0;
      ctrl_q <= CTRL_IDLE;
    end else begin
      src_q  <= src_in;
      ctrl_q <= ctrl_in;
    end
  end

  // Transparent while enable and latch enable are both low; a rise of
  // either stops reloading, leaving the pre-rise value in the bank.
  always_comb begin
    bank_ce = !ctrl_q.en_n && !ctrl_q.le_n;
    bank_d  = bank_ce ? src_q : bank_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bank_q <= '0;
    end else if (bank_ce) begin
      bank_q <= bank_d;
    end
  end

  assign drive_req = !ctrl_q.en_n && !ctrl_q.oe_n;

  // R2
  transparent_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_q.en_n && !ctrl_q.le_n) |=> (bank_q == $past(src_q)));

  // R5
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_q.en_n && ctrl_q.le_n) |=> $stable(bank_q));

  // R4
  enable_high_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q.en_n |=> $stable(bank_q));

endmodule

// File: rtl/bus_latch_xcvr.sv
module bus_latch_xcvr
  import bus_latch_xcvr_pkg::*;
#(
  parameter int unsigned WIDTH      = 8,
  parameter int unsigned RST_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] a_in,
  output logic [WIDTH-1:0] a_out,
  output logic             a_oe,
  input  logic [WIDTH-1:0] b_in,
  output logic [WIDTH-1:0] b_out,
  output logic             b_oe,
  input  logic             en_ab_n,
  input  logic             le_ab_n,
  input  logic             oe_ab_n,
  input  logic             en_ba_n,
  input  logic             le_ba_n,
  input  logic             oe_ba_n,
  output logic             contention
);

  logic                           srst_n;
  logic [NUM_DIRS-1:0][WIDTH-1:0] lane_src;
  logic [NUM_DIRS-1:0][WIDTH-1:0] lane_bank;
  dir_ctrl_t [NUM_DIRS-1:0]       lane_ctrl;
  logic [NUM_DIRS-1:0]            lane_req;
  logic [NUM_DIRS-1:0]            drv_d;
  logic [NUM_DIRS-1:0]            drv_q;
  logic                           clash_d;
  logic                           clash_q;

  xcvr_rst_sync #(.STAGES(RST_STAGES)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (srst_n)
  );

  assign lane_src[DIR_AB]  = a_in;
  assign lane_src[DIR_BA]  = b_in;
  assign lane_ctrl[DIR_AB] = '{en_n: en_ab_n, le_n: le_ab_n, oe_n: oe_ab_n};
  assign lane_ctrl[DIR_BA] = '{en_n: en_ba_n, le_n: le_ba_n, oe_n: oe_ba_n};

  for (genvar d = 0; d < NUM_DIRS; d++) begin : g_dir
    xcvr_dir_lane #(.WIDTH(WIDTH)) u_lane (
      .clk       (clk),
      .rst_n     (srst_n),
      .src_in    (lane_src[d]),
      .ctrl_in   (lane_ctrl[d]),
      .bank_q    (lane_bank[d]),
      .drive_req (lane_req[d])
    );
  end

  // Driver arbitration: a lone request drives, two requests clash
  always_comb begin
    clash_d = &lane_req;
    drv_d   = clash_d ? '0 : lane_req;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      drv_q   <= '0;
      clash_q <= 1'b0;
    end else begin
      drv_q   <= drv_d;
      clash_q <= clash_d;
    end
  end

  assign b_out      = lane_bank[DIR_AB];
  assign a_out      = lane_bank[DIR_BA];
  assign b_oe       = drv_q[DIR_AB];
  assign a_oe       = drv_q[DIR_BA];
  assign contention = clash_q;

  // R8
  single_driver_chk: assert property (@(posedge clk) disable iff (!srst_n)
    !(a_oe && b_oe));

  // R8
  clash_silences_chk: assert property (@(posedge clk) disable iff (!srst_n)
    contention |-> (!a_oe && !b_oe));

  // R6
  b_drive_origin_chk: assert property (@(posedge clk) disable iff (!srst_n)
    b_oe |-> $past(lane_req[DIR_AB]));

  // R7
  a_drive_origin_chk: assert property (@(posedge clk) disable iff (!srst_n)
    a_oe |-> $past(lane_req[DIR_BA]));

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !srst_n |-> (!a_oe && !b_oe && !contention && a_out == '0 && b_out == '0));

endmodule

// File: tb/tb_bus_latch_xcvr.sv
module tb_bus_latch_xcvr;

  localparam int unsigned W = 8;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [W-1:0] a_in, b_in, a_out, b_out;
  logic         a_oe, b_oe, contention;
  logic         en_ab_n, le_ab_n, oe_ab_n, en_ba_n, le_ba_n, oe_ba_n;

  int unsigned n_cmp = 0;
  int unsigned n_bad = 0;
  bit          done  = 1'b0;

  always #2.5 clk = ~clk;

  bus_latch_xcvr #(.WIDTH(W), .RST_STAGES(2)) dut (
    .clk(clk), .rst_n(rst_n),
    .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
    .b_in(b_in), .b_out(b_out), .b_oe(b_oe),
    .en_ab_n(en_ab_n), .le_ab_n(le_ab_n), .oe_ab_n(oe_ab_n),
    .en_ba_n(en_ba_n), .le_ba_n(le_ba_n), .oe_ba_n(oe_ba_n),
    .contention(contention)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Drive one direction (0 = A-to-B, 1 = B-to-A)
  task automatic set_dir(input int dir, input logic [W-1:0] src,
                         input logic en, input logic le, input logic oe);
    if (dir == 0) begin
      a_in = src; en_ab_n = en; le_ab_n = le; oe_ab_n = oe;
    end else begin
      b_in = src; en_ba_n = en; le_ba_n = le; oe_ba_n = oe;
    end
  endtask

  function automatic logic [W-1:0] dst_out(input int dir);
    return (dir == 0) ? b_out : a_out;
  endfunction

  function automatic logic dst_oe(input int dir);
    return (dir == 0) ? b_oe : a_oe;
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #400000;
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    a_in = '0; b_in = '0;
    en_ab_n = 1; le_ab_n = 1; oe_ab_n = 1;
    en_ba_n = 1; le_ba_n = 1; oe_ba_n = 1;
    wait_cyc(3);
    // R1 reset state
    chk("R1 a_out", a_out, 0); chk("R1 b_out", b_out, 0);
    chk("R1 a_oe", a_oe, 0);   chk("R1 b_oe", b_oe, 0);
    chk("R1 contention", contention, 0);
    rst_n = 1'b1;
    wait_cyc(5);

    // Sweep: every control combination of each direction
    for (int dir = 0; dir < 2; dir++) begin
      for (int k = 0; k < 8; k++) begin
        for (int c = 0; c < 8; c++) begin
          logic [W-1:0] p, q, exp_bank, other_before;
          logic en, le, oe;
          string tag;
          p  = W'(k * 37 + 5);
          q  = ~p;
          en = c[2]; le = c[1]; oe = c[0];
          // preload the bank with p, not driving
          set_dir(dir, p, 1'b0, 1'b0, 1'b1);
          set_dir(1 - dir, W'(k * 13 + c), 1'b1, 1'b1, 1'b1);
          wait_cyc(3);
          other_before = dst_out(1 - dir);
          // new data and new controls in the same cycle
          set_dir(dir, q, en, le, oe);
          wait_cyc(3);
          exp_bank = (!en && !le) ? q : p;
          if (!en && !le)      tag = "R2 transparent";
          else if (!en)        tag = "R3 latch-enable rise keeps";
          else                 tag = "R4 enable rise keeps";
          chk(tag, dst_out(dir), exp_bank);
          if (!en && !oe) chk("R6 drive", dst_oe(dir), 1);
          else            chk("R7 disabled", dst_oe(dir), 0);
          chk("R8 no clash", contention, 0);
          chk("R9 other bank", dst_out(1 - dir), other_before);
          chk("R9 other oe", dst_oe(1 - dir), 0);
          // hold: enable low, latch enable high, data changes
          set_dir(dir, q ^ W'(8'h5A), 1'b0, 1'b1, oe);
          wait_cyc(3);
          chk("R5 hold", dst_out(dir), exp_bank);
          chk("R6 hold drive", dst_oe(dir), !oe);
        end
      end
    end

    // R8 contention: both ask to drive
    set_dir(0, 8'h3C, 1'b0, 1'b0, 1'b0);
    set_dir(1, 8'hC3, 1'b0, 1'b0, 1'b0);
    wait_cyc(3);
    chk("R8 contention flag", contention, 1);
    chk("R8 a_oe off", a_oe, 0);
    chk("R8 b_oe off", b_oe, 0);
    chk("R2 b data during clash", b_out, 8'h3C);
    chk("R2 a data during clash", a_out, 8'hC3);
    set_dir(1, 8'hC3, 1'b0, 1'b0, 1'b1);
    wait_cyc(3);
    chk("R8 clash cleared", contention, 0);
    chk("R8 b_oe resumes", b_oe, 1);
    chk("R8 a_oe stays off", a_oe, 0);

    // R1 reset while banks hold data
    @(negedge clk);
    #1 rst_n = 1'b0;
    #0.5;
    chk("R1 async clear b_out", b_out, 0);
    chk("R1 async clear a_out", a_out, 0);
    chk("R1 async clear b_oe", b_oe, 0);
    wait_cyc(2);
    chk("R1 held reset b_oe", b_oe, 0);
    chk("R1 held reset contention", contention, 0);

    finish_run();
  end

endmodule